// File: doc/BRIEF.md
# Translation Lookaside Cache

This block keeps a small direct-mapped store of recent virtual-page to physical-page translations and sits in front of a slower segment translator. Each request carries a virtual address, a write flag and a probe flag. The block picks an entry by folding the virtual page number down to an index, and compares the virtual page stored there with the page of the request. On a usable hit it returns the result one cycle later. On any other outcome it hands the request to the slow translator and waits for its answer. When that answer is a success, the block writes it into the entry and returns the result.

Each stored entry keeps three page attributes:
- **Write-catch** forces writes onto the slow path even when the tag matches.
- **Device** sends the access to a device port. The port carries a device number and an offset in place of a memory address.
- **Executable** makes every write to the page pulse an invalidate output that carries the virtual page number.

A probe is a translation-only query. It returns the physical page number and never produces a memory or device access. When a probe misses, the slow translator sees the probe flag, so it can skip raising an exception.

A flush input empties the whole store in one cycle. It is used whenever the address width mode changes.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid. `reqReady` is 1, `slowReq` is 0, and no response pulse (`memValid`, `devValid`, `probeValid`, `errValid`, `invValid`) is active.
- R2: The entry index is `reqAddr[27:20] ^ reqAddr[19:12]`. A request hits when that entry is valid and its stored page equals `reqAddr[31:12]`, unless it is a write (not a probe) to a write-catch page. A request accepted at a clock edge has its hit response visible in the following cycle, and `slowReq` stays 0.
- R3: A memory response sets `memValid` for one cycle with `memAddr = {physical page, reqAddr[11:0]}`.
- R4: A request that does not hit raises `slowReq` in the cycle after acceptance. `slowAddr`, `slowWrite` and `slowProbe` carry the request. `slowReq` holds until `slowDone`, and `reqReady` is 0 meanwhile.
- R5: When `slowDone` is sampled with `slowErr` at 0, the response built from `slowPage` and the slow flags appears in the next cycle. The entry is refilled, so a later access to the same page hits.
- R6: A read of a write-catch page hits. A write to it always takes the slow path.
- R7: When the page has the device flag, `devValid` pulses instead of `memValid`. `devId` is the top 4 bits of the physical page, and `devOff` is the remaining 16 page bits followed by the 12 offset bits.
- R8: A non-probe write to an executable page pulses `invValid` together with its response, with `invPage = reqAddr[31:12]`. Reads of that page do not pulse it.
- R9: When `slowDone` comes with `slowErr` at 1, only `errValid` pulses in the next cycle. No memory, device or probe response is given and the entry is not refilled.
- R10: A probe returns `probeValid` with `probePage` equal to the physical page, never a memory or device response and never `invValid`. On a miss the probe reaches the slow path with `slowProbe` at 1.
- R11: `flush` invalidates every entry at the next edge, and `reqReady` is 0 while `flush` is 1.
- R12: Two pages with the same folded index evict each other, so the page that was replaced misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate every entry |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request can be accepted this cycle |
| reqAddr | input | 32 | Virtual address of the request |
| reqWrite | input | 1 | Request is a write |
| reqProbe | input | 1 | Translation-only query |
| slowReq | output | 1 | Slow translation pending |
| slowAddr | output | 32 | Address sent to the slow path |
| slowWrite | output | 1 | Write flag sent to the slow path |
| slowProbe | output | 1 | Probe flag sent to the slow path |
| slowDone | input | 1 | Slow path answer present |
| slowErr | input | 1 | Slow path failed |
| slowPage | input | 20 | Physical page number from the slow path |
| slowWrCatch | input | 1 | Page traps writes |
| slowDev | input | 1 | Page is a device page |
| slowExec | input | 1 | Page holds executable code |
| memValid | output | 1 | Memory access pulse |
| memAddr | output | 32 | Physical memory address |
| devValid | output | 1 | Device access pulse |
| devId | output | 4 | Device number |
| devOff | output | 28 | Offset inside the device |
| probeValid | output | 1 | Probe answer pulse |
| probePage | output | 20 | Physical page number for a probe |
| errValid | output | 1 | Translation failure pulse |
| invValid | output | 1 | Code invalidate pulse |
| invPage | output | 20 | Virtual page to invalidate |

## Verification
The bench uses the default parameters: 32-bit addresses, 4 KiB pages, an 8-bit index built from two folded slices, and a 4-bit device number. Its random phase confines the index slices to a few values, so these widths produce frequent hits, evictions and refills within a few hundred accesses. The slow path answers with a page and flags derived from the top address nibble, so a single address selects any mix of write-catch, device, executable and failure. Together these make every routing choice and conflict reachable with short runs.

// File: rtl/xlate_cache_pkg.sv
package xlate_cache_pkg;

  typedef struct packed {
    logic wrCatch;
    logic dev;
    logic exec;
  } pageFlags_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ctlState_t;

  typedef struct packed {
    logic accept;
    logic emitHit;
    logic finish;
    logic refill;
    logic clearAll;
  } ctlStrobe_t;

endpackage

// File: rtl/xlate_cache_ctrl.sv
module xlate_cache_ctrl
  import xlate_cache_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       reqValid,
  input  logic       lookHit,
  input  logic       lookTrap,
  input  logic       slowDone,
  input  logic       slowErr,
  output logic       reqReady,
  output logic       slowReq,
  output ctlStrobe_t ctl
);

  ctlState_t state;
  logic      accepted;

  assign reqReady = (state == ST_IDLE) && !flush;
  assign accepted = reqValid && reqReady;
  assign slowReq  = (state == ST_WAIT);

  always_comb begin
    ctl          = '0;
    ctl.accept   = accepted;
    ctl.emitHit  = accepted && lookHit && !lookTrap;
    ctl.finish   = (state == ST_WAIT) && slowDone;
    ctl.refill   = (state == ST_WAIT) && slowDone && !slowErr && !flush;
    ctl.clearAll = flush;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (accepted && !(lookHit && !lookTrap)) state <= ST_WAIT;
        ST_WAIT: if (slowDone) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlate_cache_dp.sv
module xlate_cache_dp
  import xlate_cache_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_W      = 12,
  parameter int IDX_W       = 8,
  parameter int FOLD_SLICES = 2,
  parameter int DEVID_W     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobe_t              ctl,
  input  logic [VA_W-1:0]         reqAddr,
  input  logic                    reqWrite,
  input  logic                    reqProbe,
  input  logic                    slowErr,
  input  logic [PA_W-PAGE_W-1:0]  slowPage,
  input  pageFlags_t              slowFlags,
  output logic                    lookHit,
  output logic                    lookTrap,
  output logic [VA_W-1:0]         slowAddr,
  output logic                    slowWrite,
  output logic                    slowProbe,
  output logic                    memValid,
  output logic [PA_W-1:0]         memAddr,
  output logic                    devValid,
  output logic [DEVID_W-1:0]      devId,
  output logic [PA_W-DEVID_W-1:0] devOff,
  output logic                    probeValid,
  output logic [PA_W-PAGE_W-1:0]  probePage,
  output logic                    errValid,
  output logic                    invValid,
  output logic [VA_W-PAGE_W-1:0]  invPage
);

  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int DEPTH = 1 << IDX_W;

  // Stored entries
  logic [DEPTH-1:0] entValid;
  logic [VPN_W-1:0] tagMem   [DEPTH];
  logic [PPN_W-1:0] ppnMem   [DEPTH];
  pageFlags_t       flagMem  [DEPTH];

  // Captured request while the slow path works
  logic [VA_W-1:0] qAddr;
  logic            qWrite;
  logic            qProbe;

  // Index folding, one XOR stage per slice
  logic [FOLD_SLICES:0][IDX_W-1:0] foldReq;
  logic [FOLD_SLICES:0][IDX_W-1:0] foldHeld;
  assign foldReq[0]  = '0;
  assign foldHeld[0] = '0;
  for (genvar g = 0; g < FOLD_SLICES; g++) begin : g_fold
    assign foldReq[g+1]  = foldReq[g]  ^ reqAddr[PAGE_W + g*IDX_W +: IDX_W];
    assign foldHeld[g+1] = foldHeld[g] ^ qAddr[PAGE_W + g*IDX_W +: IDX_W];
  end

  logic [IDX_W-1:0] reqIdx;
  logic [IDX_W-1:0] heldIdx;
  assign reqIdx  = foldReq[FOLD_SLICES];
  assign heldIdx = foldHeld[FOLD_SLICES];

  // Lookup
  logic [PPN_W-1:0] entPpn;
  pageFlags_t       entFlags;
  assign entPpn   = ppnMem[reqIdx];
  assign entFlags = flagMem[reqIdx];
  assign lookHit  = entValid[reqIdx] && (tagMem[reqIdx] == reqAddr[VA_W-1:PAGE_W]);
  assign lookTrap = reqWrite && !reqProbe && entFlags.wrCatch;

  assign slowAddr  = qAddr;
  assign slowWrite = qWrite;
  assign slowProbe = qProbe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qAddr  <= '0;
      qWrite <= 1'b0;
      qProbe <= 1'b0;
    end else if (ctl.accept) begin
      qAddr  <= reqAddr;
      qWrite <= reqWrite;
      qProbe <= reqProbe;
    end
  end

  // Valid bits and refill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else if (ctl.clearAll) begin
      entValid <= '0;
    end else if (ctl.refill) begin
      entValid[heldIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.refill) begin
      tagMem[heldIdx]  <= qAddr[VA_W-1:PAGE_W];
      ppnMem[heldIdx]  <= slowPage;
      flagMem[heldIdx] <= slowFlags;
    end
  end

  // Response source: fresh lookup or slow-path answer
  logic [VA_W-1:0]  srcAddr;
  logic             srcWrite;
  logic             srcProbe;
  logic [PPN_W-1:0] srcPpn;
  pageFlags_t       srcFlags;
  logic             go;

  always_comb begin
    if (ctl.emitHit) begin
      srcAddr  = reqAddr;
      srcWrite = reqWrite;
      srcProbe = reqProbe;
      srcPpn   = entPpn;
      srcFlags = entFlags;
    end else begin
      srcAddr  = qAddr;
      srcWrite = qWrite;
      srcProbe = qProbe;
      srcPpn   = slowPage;
      srcFlags = slowFlags;
    end
  end

  assign go = ctl.emitHit || (ctl.finish && !slowErr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memValid   <= 1'b0;
      devValid   <= 1'b0;
      probeValid <= 1'b0;
      errValid   <= 1'b0;
      invValid   <= 1'b0;
      memAddr    <= '0;
      devId      <= '0;
      devOff     <= '0;
      probePage  <= '0;
      invPage    <= '0;
    end else begin
      memValid   <= go && !srcProbe && !srcFlags.dev;
      devValid   <= go && !srcProbe && srcFlags.dev;
      probeValid <= go && srcProbe;
      errValid   <= ctl.finish && slowErr;
      invValid   <= go && !srcProbe && srcWrite && srcFlags.exec;
      memAddr    <= {srcPpn, srcAddr[PAGE_W-1:0]};
      devId      <= srcPpn[PPN_W-1 -: DEVID_W];
      devOff     <= {srcPpn[PPN_W-DEVID_W-1:0], srcAddr[PAGE_W-1:0]};
      probePage  <= srcPpn;
      invPage    <= srcAddr[VA_W-1:PAGE_W];
    end
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_cache_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_W      = 12,
  parameter int IDX_W       = 8,
  parameter int FOLD_SLICES = 2,
  parameter int DEVID_W     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [VA_W-1:0]         reqAddr,
  input  logic                    reqWrite,
  input  logic                    reqProbe,
  output logic                    slowReq,
  output logic [VA_W-1:0]         slowAddr,
  output logic                    slowWrite,
  output logic                    slowProbe,
  input  logic                    slowDone,
  input  logic                    slowErr,
  input  logic [PA_W-PAGE_W-1:0]  slowPage,
  input  logic                    slowWrCatch,
  input  logic                    slowDev,
  input  logic                    slowExec,
  output logic                    memValid,
  output logic [PA_W-1:0]         memAddr,
  output logic                    devValid,
  output logic [DEVID_W-1:0]      devId,
  output logic [PA_W-DEVID_W-1:0] devOff,
  output logic                    probeValid,
  output logic [PA_W-PAGE_W-1:0]  probePage,
  output logic                    errValid,
  output logic                    invValid,
  output logic [VA_W-PAGE_W-1:0]  invPage
);

  ctlStrobe_t ctl;
  pageFlags_t slowFlags;
  logic       lookHit;
  logic       lookTrap;

  assign slowFlags = '{wrCatch: slowWrCatch, dev: slowDev, exec: slowExec};

  xlate_cache_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .reqValid (reqValid),
    .lookHit  (lookHit),
    .lookTrap (lookTrap),
    .slowDone (slowDone),
    .slowErr  (slowErr),
    .reqReady (reqReady),
    .slowReq  (slowReq),
    .ctl      (ctl)
  );

  xlate_cache_dp #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_W(PAGE_W), .IDX_W(IDX_W),
    .FOLD_SLICES(FOLD_SLICES), .DEVID_W(DEVID_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqWrite   (reqWrite),
    .reqProbe   (reqProbe),
    .slowErr    (slowErr),
    .slowPage   (slowPage),
    .slowFlags  (slowFlags),
    .lookHit    (lookHit),
    .lookTrap   (lookTrap),
    .slowAddr   (slowAddr),
    .slowWrite  (slowWrite),
    .slowProbe  (slowProbe),
    .memValid   (memValid),
    .memAddr    (memAddr),
    .devValid   (devValid),
    .devId      (devId),
    .devOff     (devOff),
    .probeValid (probeValid),
    .probePage  (probePage),
    .errValid   (errValid),
    .invValid   (invValid),
    .invPage    (invPage)
  );

endmodule

// File: rtl/xlate_cache_checker.sv
module xlate_cache_checker (
  input logic clk,
  input logic rstN,
  input logic flush,
  input logic reqReady,
  input logic slowReq,
  input logic slowDone,
  input logic memValid,
  input logic devValid,
  input logic probeValid,
  input logic errValid,
  input logic invValid
);

  // R4: a pending slow request stays up until answered
  a_r4_slow_held: assert property (@(posedge clk) disable iff (!rstN)
    slowReq && !slowDone |=> slowReq);

  // R4: no new request accepted while the slow path works
  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    slowReq |-> !reqReady);

  // R5 / R9: an answered slow request produces exactly one kind of response
  a_r5_answer_responds: assert property (@(posedge clk) disable iff (!rstN)
    slowReq && slowDone |=> (memValid || devValid || probeValid || errValid));

  // R7 / R9: response kinds are mutually exclusive
  a_r7_one_route: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memValid, devValid, probeValid, errValid}));

  // R10: probes never request code invalidation
  a_r10_probe_no_inv: assert property (@(posedge clk) disable iff (!rstN)
    probeValid |-> !invValid);

  // R8: invalidation only accompanies an access
  a_r8_inv_with_access: assert property (@(posedge clk) disable iff (!rstN)
    invValid |-> (memValid || devValid));

  // R11: flushing blocks acceptance
  a_r11_flush_blocks: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !reqReady);

endmodule

bind xlate_cache xlate_cache_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .reqReady   (reqReady),
  .slowReq    (slowReq),
  .slowDone   (slowDone),
  .memValid   (memValid),
  .devValid   (devValid),
  .probeValid (probeValid),
  .errValid   (errValid),
  .invValid   (invValid)
);

// File: tb/xlate_cache_test.sv
module xlate_cache_test;

  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqProbe = 1'b0;
  logic        slowReq;
  logic [31:0] slowAddr;
  logic        slowWrite;
  logic        slowProbe;
  logic        slowDone = 1'b0;
  logic        slowErr = 1'b0;
  logic [19:0] slowPage = '0;
  logic        slowWrCatch = 1'b0;
  logic        slowDev = 1'b0;
  logic        slowExec = 1'b0;
  logic        memValid;
  logic [31:0] memAddr;
  logic        devValid;
  logic [3:0]  devId;
  logic [27:0] devOff;
  logic        probeValid;
  logic [19:0] probePage;
  logic        errValid;
  logic        invValid;
  logic [19:0] invPage;

  always #5 clk = ~clk;

  xlate_cache uut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqProbe(reqProbe),
    .slowReq(slowReq), .slowAddr(slowAddr), .slowWrite(slowWrite),
    .slowProbe(slowProbe), .slowDone(slowDone), .slowErr(slowErr),
    .slowPage(slowPage), .slowWrCatch(slowWrCatch), .slowDev(slowDev),
    .slowExec(slowExec),
    .memValid(memValid), .memAddr(memAddr), .devValid(devValid),
    .devId(devId), .devOff(devOff), .probeValid(probeValid),
    .probePage(probePage), .errValid(errValid), .invValid(invValid),
    .invPage(invPage)
  );

  typedef logic [108:0] bundle_t;

  integer nCmp = 0;
  integer nBad = 0;
  bit     finished = 1'b0;

  // Reference state: presence and stored page per index
  bit          refValid [256];
  logic [19:0] refTag   [256];

  function automatic logic [7:0] hashOf(input logic [31:0] va);
    return va[27:20] ^ va[19:12];
  endfunction

  // Slow-path translation function: flags come from the top nibble
  function automatic logic [19:0] pageOf(input logic [31:0] va);
    return va[31:12] ^ 20'h3C5A6;
  endfunction

  function automatic bundle_t pack(input logic mv, input logic [31:0] ma,
                                   input logic dv, input logic [3:0] di,
                                   input logic [27:0] dof, input logic pv,
                                   input logic [19:0] pp, input logic ev,
                                   input logic iv, input logic [19:0] ip);
    return {mv, mv ? ma : 32'h0, dv, dv ? di : 4'h0, dv ? dof : 28'h0,
            pv, pv ? pp : 20'h0, ev, iv, iv ? ip : 20'h0};
  endfunction

  function automatic bundle_t actual();
    return pack(memValid, memAddr, devValid, devId, devOff, probeValid,
                probePage, errValid, invValid, invPage);
  endfunction

  function automatic bundle_t expected(input logic [31:0] va, input logic wr,
                                       input logic pr, input logic err);
    logic [19:0] pg;
    logic        isDev;
    logic        isExec;
    pg     = pageOf(va);
    isDev  = va[29];
    isExec = va[30];
    if (err)
      return pack(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    if (pr)
      return pack(0, 0, 0, 0, 0, 1, pg, 0, 0, 0);
    return pack(!isDev, {pg, va[11:0]}, isDev, pg[19:16], {pg[15:0], va[11:0]},
                0, 0, 0, wr && isExec, va[31:12]);
  endfunction

  task automatic cmpBundle(input string req, input bundle_t exp);
    bundle_t act;
    act = actual();
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: outputs actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmpVal(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One request, checked on every cycle until its response
  task automatic access(input logic [31:0] va, input logic wr, input logic pr,
                        input string req);
    logic [7:0] idx;
    bit         hit;
    @(negedge clk);
    cmpBundle({req, " idle"}, '0);
    cmpVal(req, "reqReady", {31'b0, reqReady}, 32'h1);
    reqAddr  = va;
    reqWrite = wr;
    reqProbe = pr;
    reqValid = 1'b1;
    idx = hashOf(va);
    hit = refValid[idx] && (refTag[idx] == va[31:12]) && !(wr && !pr && va[28]);
    @(negedge clk);
    reqValid = 1'b0;
    if (hit) begin
      cmpBundle({req, " hit"}, expected(va, wr, pr, 1'b0));
      cmpVal(req, "slowReq on hit", {31'b0, slowReq}, 32'h0);
    end else begin
      cmpVal(req, "slowReq", {31'b0, slowReq}, 32'h1);
      cmpVal(req, "slowAddr", slowAddr, va);
      cmpVal(req, "slowWrite/slowProbe", {30'b0, slowWrite, slowProbe}, {30'b0, wr, pr});
      cmpVal(req, "reqReady busy", {31'b0, reqReady}, 32'h0);
      cmpBundle({req, " waiting"}, '0);
      repeat (2) begin
        @(negedge clk);
        cmpVal(req, "slowReq held", {31'b0, slowReq}, 32'h1);
        cmpBundle({req, " waiting"}, '0);
      end
      slowDone    = 1'b1;
      slowErr     = va[31];
      slowPage    = pageOf(va);
      slowWrCatch = va[28];
      slowDev     = va[29];
      slowExec    = va[30];
      @(negedge clk);
      slowDone = 1'b0;
      slowErr  = 1'b0;
      cmpBundle({req, " answered"}, expected(va, wr, pr, va[31]));
      cmpVal(req, "slowReq dropped", {31'b0, slowReq}, 32'h0);
      if (!va[31]) begin
        refValid[idx] = 1'b1;
        refTag[idx]   = va[31:12];
      end
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    #1;
    cmpVal("R11", "reqReady during flush", {31'b0, reqReady}, 32'h0);
    @(negedge clk);
    flush = 1'b0;
    foreach (refValid[i]) refValid[i] = 1'b0;
  endtask

  initial begin
    #(MAX_CYCLES * 10);
    if (!finished) begin
      nBad++;
      nCmp++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rnd;
    logic [31:0] va;
    foreach (refValid[i]) refValid[i] = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    cmpBundle("R1 reset", '0);
    cmpVal("R1", "reqReady", {31'b0, reqReady}, 32'h1);
    cmpVal("R1", "slowReq", {31'b0, slowReq}, 32'h0);

    access(32'h0012_3456, 0, 0, "R4 R5 read miss");
    access(32'h0012_3ABC, 0, 0, "R2 R3 read hit");
    access(32'h0012_3004, 1, 0, "R2 write hit");
    access(32'h1045_6010, 0, 0, "R6 write-catch read miss");
    access(32'h1045_6018, 0, 0, "R6 write-catch read hit");
    access(32'h1045_601C, 1, 0, "R6 write trapped");
    access(32'h2078_9020, 0, 0, "R7 device miss");
    access(32'h2078_9FF0, 1, 0, "R7 device hit");
    access(32'h40AB_C030, 1, 0, "R8 exec write miss");
    access(32'h40AB_C034, 1, 0, "R8 exec write hit");
    access(32'h40AB_C038, 0, 0, "R8 exec read");
    access(32'h60CD_E000, 1, 0, "R7 R8 device exec write");
    access(32'h80DE_F040, 0, 0, "R9 failure");
    access(32'h80DE_F044, 0, 0, "R9 not refilled");
    access(32'h0012_3100, 0, 1, "R10 probe hit");
    access(32'h0034_5678, 0, 1, "R10 probe miss");
    access(32'h0034_5000, 0, 0, "R10 probe refill used");
    access(32'h80DE_F048, 0, 1, "R9 R10 probe failure");
    access(32'h0220_0111, 0, 0, "R12 conflict fill");
    access(32'h0012_3456, 0, 0, "R12 evicted page misses");
    doFlush();
    access(32'h0012_3456, 0, 0, "R11 miss after flush");
    access(32'h2078_9020, 0, 0, "R11 device miss after flush");

    // Mixed traffic over few indices
    for (int i = 0; i < 400; i++) begin
      rnd = $urandom;
      va  = {rnd[31] & rnd[30], rnd[29:27], 6'b0, rnd[26:25], 5'b0, rnd[24:22], rnd[11:0]};
      access(va, rnd[21], rnd[20] & rnd[19], "R2 R5 R12 mixed");
      if (i == 200) doFlush();
    end

    @(negedge clk);
    cmpBundle("R1 quiet end", '0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule